// File: doc/BRIEF.md
# Burst-Interleaving Segment Scheduler

This block merges two upstream packet sources onto one shared transmit bus. Each source offers a packet one 16-byte segment per transfer. A transfer is a valid/ready beat, and a last flag marks the final segment. The scheduler moves one segment per clock onto the output. Each output segment carries a code that marks it as start, middle, end, start-and-end or idle. It also carries the source number of the packet it came from, so a receiver can pull interleaved bursts apart again.

Packets are cut into bursts of at most `BURST_MAX_SEGS` segments (16 by default, which is 256 bytes). A burst that does not end its packet is always exactly that long. At each burst boundary the scheduler alternates round-robin between the sources that have data. In interleaved mode it may therefore park a packet after a full burst and resume it later. In packet mode (`INTERLEAVE = 0`) a packet is sent without interruption from start to end. A burst that ends a packet is never shorter than `BURST_MIN_SEGS` segments (4 by default, which is 64 bytes): idle segments pad it out. When the downstream ready is low, the output is idle and nothing is taken from either source.

Top module: `burst_seg_scheduler`

## Requirements
- R1: Each output segment carries a 3-bit code: 0 idle, 1 start of packet, 2 middle of packet, 3 end of packet, 4 start and end in one segment. The first segment of a packet is coded 1 (or 4 if it is also the last), the final segment is coded 3, and every other segment is coded 2.
- R2: A burst that does not end its packet is exactly `BURST_MAX_SEGS` segments long. After such a burst, the next segment is scheduled afresh at the burst boundary.
- R3: In interleaved mode, after a full burst of one source's packet, the other source gets the next burst if it has data. A resumed packet's next burst starts with code 2, not code 1.
- R4: In packet mode, once a packet has started, no segment of the other source appears until that packet's final segment has been sent.
- R5: When a packet's final burst has k < `BURST_MIN_SEGS` segments, the next `BURST_MIN_SEGS` - k cycles with downstream ready high output idle segments. This holds even when data is pending. A final burst of `BURST_MIN_SEGS` segments or more gets no padding.
- R6: While the downstream ready is low, the output code is idle and neither source ready is asserted. The burst in progress resumes unchanged afterwards.
- R7: At each burst boundary the source other than the one that sent the previous burst is chosen if it has data; otherwise the same source continues. After reset, source 0 is served first.
- R8: For a non-idle segment, the output source number names the source the segment was taken from. The output data equals that source's segment, and exactly that source's ready is high in that cycle.
- R9: During reset the output code is idle and both source ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcValid | input | 2 | Per source: a segment is offered |
| srcLast | input | 2 | Per source: the offered segment ends its packet |
| srcData | input | 2*SEG_W | Offered segments, source 0 in the low half |
| srcReady | output | 2 | Per source: the offered segment is taken this cycle |
| outReady | input | 1 | Downstream can accept a segment this cycle |
| outCode | output | 3 | Segment code (0 idle, 1 start, 2 middle, 3 end, 4 start and end) |
| outSrc | output | 1 | Source number of the segment |
| outData | output | SEG_W | Segment payload, zero when idle |

## Verification
Two instances run side by side, one interleaved and one in packet mode, fed with the same mix of packets: 20, 2, 3 and 1 segments long. The two output sequences differ only in whether the long packet is parked after its first 16 segments, which isolates the interleaving decision and the code given to a resumed burst. The mix also covers final bursts of one, two, three and four segments, so each padding length and the no-padding boundary appear. Directed runs follow. Downstream backpressure falls in the middle of a burst, to show that the burst holds and resumes. A 17-segment packet is followed at once by a pending one-segment packet, to show that padding holds off waiting data.

// File: rtl/seg_sched_pkg.sv
package seg_sched_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE   = 3'd0,
    SEG_SOP    = 3'd1,
    SEG_DAT    = 3'd2,
    SEG_EOP    = 3'd3,
    SEG_SOPEOP = 3'd4
  } seg_code_e;

  // Strobes from the control to the datapath for one output cycle
  typedef struct packed {
    logic      take;   // a segment moves this cycle
    logic      sel;    // source it is taken from
    seg_code_e code;   // code put on the bus
  } sched_ctl_t;

endpackage

// File: rtl/seg_sched_ctrl.sv
module seg_sched_ctrl
  import seg_sched_pkg::*;
#(
  parameter int BURST_MAX_SEGS = 16,
  parameter int BURST_MIN_SEGS = 4,
  parameter bit INTERLEAVE     = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] srcValid,
  input  logic [1:0] srcLast,
  input  logic       outReady,
  output sched_ctl_t ctl
);

  localparam int CNT_W = $clog2(BURST_MAX_SEGS + 1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(BURST_MAX_SEGS);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(BURST_MIN_SEGS);

  logic             inBurst;
  logic             cur;
  logic             lastSrc;
  logic [CNT_W-1:0] burstCnt;
  logic [CNT_W-1:0] padLeft;
  logic [1:0]       started;

  logic             pick;
  logic             other;
  logic             take;
  logic             isLast;
  logic             first;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;

  // Source choice, the segment code and the take strobe
  always_comb begin
    other = ~lastSrc;
    if (inBurst)
      pick = cur;
    else if (!INTERLEAVE && started[lastSrc])
      pick = lastSrc;
    else if (srcValid[other])
      pick = other;
    else
      pick = lastSrc;

    cnt     = inBurst ? burstCnt : '0;
    cntNext = cnt + 1'b1;
    take    = !rst && outReady && (padLeft == '0) && srcValid[pick];
    isLast  = srcLast[pick];
    first   = !started[pick];

    ctl.take = take;
    ctl.sel  = pick;
    ctl.code = SEG_IDLE;
    if (take) begin
      unique case ({first, isLast})
        2'b11:   ctl.code = SEG_SOPEOP;
        2'b10:   ctl.code = SEG_SOP;
        2'b01:   ctl.code = SEG_EOP;
        default: ctl.code = SEG_DAT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inBurst  <= 1'b0;
      cur      <= 1'b0;
      lastSrc  <= 1'b1;
      burstCnt <= '0;
      padLeft  <= '0;
      started  <= '0;
    end else begin
      if (outReady && padLeft != '0)
        padLeft <= padLeft - 1'b1;
      if (take) begin
        started[pick] <= !isLast;
        if (isLast) begin
          inBurst  <= 1'b0;
          lastSrc  <= pick;
          burstCnt <= '0;
          padLeft  <= (cntNext < MIN_C) ? (MIN_C - cntNext) : '0;
        end else if (cntNext == MAX_C) begin
          inBurst  <= 1'b0;
          lastSrc  <= pick;
          burstCnt <= '0;
        end else begin
          inBurst  <= 1'b1;
          cur      <= pick;
          burstCnt <= cntNext;
        end
      end
    end
  end

  // R6: backpressure leaves the bus idle
  a_r6_idle_when_blocked: assert property (@(posedge clk) disable iff (rst)
    !outReady |-> ctl.code == SEG_IDLE);

  // R2: an open burst never reaches the maximum length
  a_r2_burst_limit: assert property (@(posedge clk) disable iff (rst)
    inBurst |-> (burstCnt != '0) && (burstCnt < MAX_C));

  // R5: nothing is taken while padding remains
  a_r5_pad_quiet: assert property (@(posedge clk) disable iff (rst)
    padLeft != '0 |-> !ctl.take);

  // R3: a packet already under way never restarts with a start code
  a_r3_resume_dat: assert property (@(posedge clk) disable iff (rst)
    (ctl.take && started[ctl.sel]) |-> (ctl.code == SEG_DAT || ctl.code == SEG_EOP));

  // R5: padding is loaded only after a short final burst
  a_r5_pad_after_eop: assert property (@(posedge clk) disable iff (rst)
    $rose(padLeft != '0) |-> $past(ctl.code == SEG_EOP || ctl.code == SEG_SOPEOP));

  generate
    if (!INTERLEAVE) begin : g_pkt_mode
      // R4: at most one packet open at a time
      a_r4_single_open: assert property (@(posedge clk) disable iff (rst)
        $countones(started) <= 1);
    end
  endgenerate

endmodule

// File: rtl/seg_sched_dpath.sv
module seg_sched_dpath
  import seg_sched_pkg::*;
#(
  parameter int SEG_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  sched_ctl_t         ctl,
  input  logic [2*SEG_W-1:0] srcData,
  output logic [1:0]         srcReady,
  output logic [2:0]         outCode,
  output logic               outSrc,
  output logic [SEG_W-1:0]   outData
);

  always_comb begin
    outCode  = ctl.code;
    outSrc   = ctl.sel;
    outData  = ctl.take ? srcData[ctl.sel*SEG_W +: SEG_W] : '0;
    srcReady = ctl.take ? (2'b01 << ctl.sel) : 2'b00;
  end

  // R8: at most one source is drained per cycle
  a_r8_ready_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(srcReady));

  // R8: a drained segment always shows on the bus
  a_r8_ready_has_seg: assert property (@(posedge clk) disable iff (rst)
    (|srcReady) |-> outCode != SEG_IDLE);

endmodule

// File: rtl/burst_seg_scheduler.sv
module burst_seg_scheduler
  import seg_sched_pkg::*;
#(
  parameter int SEG_W          = 128,
  parameter int BURST_MAX_SEGS = 16,
  parameter int BURST_MIN_SEGS = 4,
  parameter bit INTERLEAVE     = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         srcValid,
  input  logic [1:0]         srcLast,
  input  logic [2*SEG_W-1:0] srcData,
  output logic [1:0]         srcReady,
  input  logic               outReady,
  output logic [2:0]         outCode,
  output logic               outSrc,
  output logic [SEG_W-1:0]   outData
);

  sched_ctl_t ctl;

  seg_sched_ctrl #(
    .BURST_MAX_SEGS(BURST_MAX_SEGS),
    .BURST_MIN_SEGS(BURST_MIN_SEGS),
    .INTERLEAVE    (INTERLEAVE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .srcValid(srcValid),
    .srcLast (srcLast),
    .outReady(outReady),
    .ctl     (ctl)
  );

  seg_sched_dpath #(
    .SEG_W(SEG_W)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .srcData (srcData),
    .srcReady(srcReady),
    .outCode (outCode),
    .outSrc  (outSrc),
    .outData (outData)
  );

endmodule

// File: tb/burst_seg_scheduler_bench.sv
module burst_seg_scheduler_bench;

  localparam int SEG_W = 128;
  localparam int NVEC  = 34;

  // Per cycle: {codeA[2:0], srcA, codeB[2:0], srcB}; A interleaved, B packet mode
  localparam logic [7:0] VEC [NVEC] = '{
    8'h22, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44,
    8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44,
    8'h34, 8'h54, 8'h74, 8'h06, 8'h43, 8'h45, 8'h47, 8'h60,
    8'h92, 8'h06, 8'h00, 8'h00, 8'h29, 8'h60, 8'h00, 8'h00,
    8'h00, 8'h00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic outReady = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]         vld  [2];
  logic [1:0]         lst  [2];
  logic [1:0]         sRdy [2];
  logic [2*SEG_W-1:0] dat  [2];
  logic [2:0]         code [2];
  logic               osrc [2];
  logic [SEG_W-1:0]   odat [2];

  int pktLen [2][2][4];
  int nPkt   [2][2];
  int pkIdx  [2][2];
  int sgIdx  [2][2];
  int sent   [2][2];
  int expCnt [2][2];
  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  burst_seg_scheduler #(.SEG_W(SEG_W), .INTERLEAVE(1'b1)) u_burst_seg_scheduler (
    .clk(clk), .rst(rst), .srcValid(vld[0]), .srcLast(lst[0]), .srcData(dat[0]),
    .srcReady(sRdy[0]), .outReady(outReady), .outCode(code[0]), .outSrc(osrc[0]),
    .outData(odat[0]));

  burst_seg_scheduler #(.SEG_W(SEG_W), .INTERLEAVE(1'b0)) u_burst_seg_scheduler_pkt (
    .clk(clk), .rst(rst), .srcValid(vld[1]), .srcLast(lst[1]), .srcData(dat[1]),
    .srcReady(sRdy[1]), .outReady(outReady), .outCode(code[1]), .outSrc(osrc[1]),
    .outData(odat[1]));

  // Behavioural sources: payload is {source bit, 16-bit running segment count}
  always_comb begin
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        vld[d][s] = 1'b0;
        lst[d][s] = 1'b0;
        if (pkIdx[d][s] < nPkt[d][s]) begin
          vld[d][s] = 1'b1;
          lst[d][s] = (sgIdx[d][s] == pktLen[d][s][pkIdx[d][s]] - 1);
        end
        dat[d][s*SEG_W +: SEG_W] = SEG_W'({s[0], sent[d][s][15:0]});
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadSrc(int d, int s, int l0, int l1);
    pktLen[d][s][0] = l0;
    pktLen[d][s][1] = l1;
    nPkt[d][s]  = (l0 != 0 ? 1 : 0) + (l1 != 0 ? 1 : 0);
    pkIdx[d][s] = 0;
    sgIdx[d][s] = 0;
  endtask

  task automatic step(logic rdy, logic [7:0] vec, string reqA, string reqB);
    logic [1:0] took [2];
    logic [2:0] eCode;
    logic       eSrc;
    @(negedge clk);
    outReady = rdy;
    #1;
    for (int d = 0; d < 2; d++) begin
      eCode = (d == 0) ? vec[7:5] : vec[3:1];
      eSrc  = (d == 0) ? vec[4]   : vec[0];
      chk((d == 0) ? reqA : reqB, int'(code[d]), int'(eCode));
      if (eCode != 3'd0) begin
        chk("R8 source tag", int'(osrc[d]), int'(eSrc));
        chk("R8 payload", int'(odat[d][16:0]), int'({eSrc, expCnt[d][eSrc][15:0]}));
        chk("R8 ready select", int'(sRdy[d]), (eSrc ? 2 : 1));
        expCnt[d][eSrc]++;
      end
      if (!rdy) chk("R6 no ready under backpressure", int'(sRdy[d]), 0);
      took[d] = sRdy[d];
    end
    @(posedge clk);
    #1;
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        if (took[d][s]) begin
          sent[d][s]++;
          if (sgIdx[d][s] == pktLen[d][s][pkIdx[d][s]] - 1) begin
            pkIdx[d][s]++;
            sgIdx[d][s] = 0;
          end else begin
            sgIdx[d][s]++;
          end
        end
      end
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        sent[d][s] = 0;
        expCnt[d][s] = 0;
        for (int k = 0; k < 4; k++) pktLen[d][s][k] = 0;
      end
      loadSrc(d, 0, 20, 2);
      loadSrc(d, 1, 3, 1);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R9: reset state with data offered
    for (int d = 0; d < 2; d++) begin
      chk("R9 idle in reset", int'(code[d]), 0);
      chk("R9 no ready in reset", int'(sRdy[d]), 0);
    end
    rst = 1'b0;

    // Shared mix: R1 R2 R3 R5 R7 on the interleaved unit, R4 on the packet-mode unit
    for (int i = 0; i < NVEC; i++)
      step(1'b1, VEC[i], "R1 R2 R3 R5 R7 interleaved code", "R4 packet mode code");

    // R6: backpressure in mid burst holds and resumes the burst
    loadSrc(0, 0, 6, 0);
    step(1'b1, 8'h20, "R6 start", "R6 other idle");
    step(1'b1, 8'h40, "R6 second", "R6 other idle");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, "R6 held idle", "R6 other idle");
    for (int i = 0; i < 3; i++) step(1'b1, 8'h40, "R6 resumed", "R6 other idle");
    step(1'b1, 8'h60, "R6 end", "R6 other idle");

    // R2 and R5: 17 segments then one, padding holds off the pending packet
    loadSrc(0, 0, 17, 1);
    step(1'b1, 8'h20, "R2 start", "R2 other idle");
    for (int i = 0; i < 15; i++) step(1'b1, 8'h40, "R2 burst body", "R2 other idle");
    step(1'b1, 8'h60, "R2 one-segment final burst", "R2 other idle");
    for (int i = 0; i < 3; i++) step(1'b1, 8'h00, "R5 padding with data pending", "R5 other idle");
    step(1'b1, 8'h80, "R1 start and end code", "R1 other idle");
    for (int i = 0; i < 3; i++) step(1'b1, 8'h00, "R5 padding after single", "R5 other idle");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule